// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block sits between a bank of raw interrupt lines and an interrupt arbiter. It samples every line on each clock, compares the sample with the level it held one clock earlier, and turns the result into a per-source pending flag. Each source has a trigger mode: level, falling edge, rising edge or any edge. Whenever a source raises a fresh request, the block pulses a one-clock request strobe for the arbiter. A level source also pulses a withdraw strobe when its line drops, so the arbiter can cancel a request that has not been served.

A level source's flag follows its line. An edge source's flag stays set until software clears it or the arbiter acknowledges that source. A small byte-wide register port gives software two windows. One window holds one pending-flag register per source. The other holds one trigger-mode register for each source in a contiguous block of external pins, starting at source `EXT_BASE`. Sources outside that block keep the mode they are given at reset. Inputs are taken to be synchronous to the clock.

Top module: `trig_detect`

## Requirements
- R1: During and after reset every pending flag and every strobe is 0. Every source starts in rising-edge mode, except the sources marked in `LEVEL_INIT`, which start in level mode (defaults: sources 3 and 70).
- R2: In level mode (code 00), a high input sets the pending flag at the next clock edge. A request strobe is raised in that same cycle only when the flag was clear.
- R3: In level mode, a low input on a source whose flag is set clears the flag and raises the withdraw strobe for exactly one cycle.
- R4: In falling-edge mode (code 01), a request is raised when the previous sample is 1 and the current sample is 0. A rise has no effect.
- R5: In rising-edge mode (code 10), a request is raised when the previous sample is 0 and the current sample is 1. A fall has no effect.
- R6: In any-edge mode (code 11), every change of the input raises a request.
- R7: The previous-sample register of every source is updated on every clock, whatever the mode. After a mode change, an edge is therefore judged against the true previous level.
- R8: Register address bit 7 set selects the mode window. The low bits select the register, and register k controls source `EXT_BASE`+k. A write stores write-data bits 3:2 as the mode and ignores all other bits. A read returns the mode in bits 3:2 with every other bit 0.
- R9: Register address bit 7 clear selects the pending window, and index i selects source i. Writing 0 clears the flag of an edge-mode source. Writes of nonzero data, and any write to a level-mode source, leave the flag unchanged.
- R10: A read of a pending register returns the flag in bit 0 with bits 7:1 zero.
- R11: An acknowledge naming a source clears that source's flag when it is in an edge mode. It has no effect on a level source.
- R12: When an edge event and a clear (by write or by acknowledge) reach the same source in the same cycle, the event wins: the flag stays set and a request strobe is raised.
- R13: A single edge produces a request strobe exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_i | input | NUM_SRC | Raw interrupt lines, synchronous to clk |
| ack_valid_i | input | 1 | Arbiter acknowledge strobe |
| ack_id_i | input | ID_W | Source number being acknowledged |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | ID_W+1 | Register address; the top bit selects the window |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| pend_o | output | NUM_SRC | Pending flags |
| req_stb_o | output | NUM_SRC | One-cycle new-request strobes |
| wdraw_stb_o | output | NUM_SRC | One-cycle withdraw strobes for level sources |

## Verification
The bench drives each trigger mode with rise-only, fall-only and rise-then-fall patterns, and checks that only the intended transition sets the flag. A level source is held high over several cycles and then dropped. This shows that it requests once and withdraws once, rather than repeating its request. A mode switch made while the line is already high separates a true previous-sample register from one that only updates on events. Clears and acknowledges are issued both alone and in the same cycle as a new edge, which exposes the priority between setting and clearing a flag.

// File: rtl/trig_detect_pkg.sv
package trig_detect_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_RISE  = 2'b10,
        TRIG_BOTH  = 2'b11
    } trig_mode_e;

    localparam int MODE_LSB = 2;
    localparam int REG_W    = 8;

endpackage

// File: rtl/trig_src_cell.sv
module trig_src_cell
    import trig_detect_pkg::*;
(
    input  trig_mode_e mode_i,
    input  logic       in_i,
    input  logic       prev_i,
    input  logic       pend_i,
    input  logic       clr_i,
    output logic       pend_o,
    output logic       req_o,
    output logic       wdraw_o
);

    logic rise_w;
    logic fall_w;
    logic edge_ev;

    assign rise_w = in_i & ~prev_i;
    assign fall_w = ~in_i & prev_i;

    always_comb begin
        edge_ev = 1'b0;
        pend_o  = pend_i;
        req_o   = 1'b0;
        wdraw_o = 1'b0;
        case (mode_i)
            TRIG_FALL: edge_ev = fall_w;
            TRIG_RISE: edge_ev = rise_w;
            TRIG_BOTH: edge_ev = rise_w | fall_w;
            default:   edge_ev = 1'b0;
        endcase
        if (mode_i == TRIG_LEVEL) begin
            pend_o  = in_i;
            req_o   = in_i & ~pend_i;
            wdraw_o = ~in_i & pend_i;
        end else begin
            pend_o = edge_ev | (pend_i & ~clr_i);
            req_o  = edge_ev;
        end
    end

endmodule

// File: rtl/trig_reg_port.sv
module trig_reg_port
    import trig_detect_pkg::*;
#(
    parameter int NUM_SRC   = 96,
    parameter int EXT_BASE  = 64,
    parameter int EXT_COUNT = 32,
    parameter int ID_W      = $clog2(NUM_SRC)
) (
    input  logic                     reg_wr_i,
    input  logic [ID_W:0]            reg_addr_i,
    input  logic [REG_W-1:0]         reg_wdata_i,
    input  logic                     ack_valid_i,
    input  logic [ID_W-1:0]          ack_id_i,
    input  logic [NUM_SRC-1:0]       pend_i,
    input  logic [NUM_SRC-1:0][1:0]  mode_i,
    output logic [NUM_SRC-1:0]       clr_o,
    output logic [EXT_COUNT-1:0]     mode_wr_o,
    output logic [1:0]               mode_val_o,
    output logic [REG_W-1:0]         rdata_o
);

    logic            win_mode;
    logic [ID_W-1:0] idx;
    logic            zero_wr;

    assign win_mode   = reg_addr_i[ID_W];
    assign idx        = reg_addr_i[ID_W-1:0];
    assign zero_wr    = reg_wr_i & ~win_mode & (reg_wdata_i == '0);
    assign mode_val_o = reg_wdata_i[MODE_LSB+1:MODE_LSB];

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            clr_o[i] = (zero_wr & (idx == ID_W'(i))) |
                       (ack_valid_i & (ack_id_i == ID_W'(i)));
        end
    end

    always_comb begin
        for (int k = 0; k < EXT_COUNT; k++) begin
            mode_wr_o[k] = reg_wr_i & win_mode & (idx == ID_W'(k));
        end
    end

    always_comb begin
        rdata_o = '0;
        if (win_mode) begin
            for (int k = 0; k < EXT_COUNT; k++) begin
                if (idx == ID_W'(k)) begin
                    rdata_o[MODE_LSB+1:MODE_LSB] = mode_i[EXT_BASE+k];
                end
            end
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (idx == ID_W'(i)) begin
                    rdata_o[0] = pend_i[i];
                end
            end
        end
    end

endmodule

// File: rtl/trig_detect.sv
module trig_detect
    import trig_detect_pkg::*;
#(
    parameter int                NUM_SRC    = 96,
    parameter int                EXT_BASE   = 64,
    parameter int                EXT_COUNT  = 32,
    parameter logic [NUM_SRC-1:0] LEVEL_INIT = (NUM_SRC'(1) << 70) | (NUM_SRC'(1) << 3),
    parameter int                ID_W       = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic               ack_valid_i,
    input  logic [ID_W-1:0]    ack_id_i,
    input  logic               reg_wr_i,
    input  logic [ID_W:0]      reg_addr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] req_stb_o,
    output logic [NUM_SRC-1:0] wdraw_stb_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0]      prev;
        logic [NUM_SRC-1:0]      pend;
        logic [NUM_SRC-1:0]      req;
        logic [NUM_SRC-1:0]      wdr;
        logic [NUM_SRC-1:0][1:0] mode;
    } state_t;

    function automatic logic [NUM_SRC-1:0][1:0] reset_modes();
        logic [NUM_SRC-1:0][1:0] m;
        for (int i = 0; i < NUM_SRC; i++) begin
            m[i] = LEVEL_INIT[i] ? TRIG_LEVEL : TRIG_RISE;
        end
        return m;
    endfunction

    localparam logic [NUM_SRC-1:0][1:0] MODE_RST = reset_modes();

    state_t state_d;
    state_t state_q;

    logic [NUM_SRC-1:0]   clr_w;
    logic [EXT_COUNT-1:0] mode_wr_w;
    logic [1:0]           mode_val_w;
    logic [NUM_SRC-1:0]   pend_nx;
    logic [NUM_SRC-1:0]   req_nx;
    logic [NUM_SRC-1:0]   wdr_nx;

    trig_reg_port #(
        .NUM_SRC   (NUM_SRC),
        .EXT_BASE  (EXT_BASE),
        .EXT_COUNT (EXT_COUNT),
        .ID_W      (ID_W)
    ) regs_i (
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .ack_valid_i (ack_valid_i),
        .ack_id_i    (ack_id_i),
        .pend_i      (state_q.pend),
        .mode_i      (state_q.mode),
        .clr_o       (clr_w),
        .mode_wr_o   (mode_wr_w),
        .mode_val_o  (mode_val_w),
        .rdata_o     (reg_rdata_o)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        trig_src_cell cell_i (
            .mode_i  (trig_mode_e'(state_q.mode[g])),
            .in_i    (irq_i[g]),
            .prev_i  (state_q.prev[g]),
            .pend_i  (state_q.pend[g]),
            .clr_i   (clr_w[g]),
            .pend_o  (pend_nx[g]),
            .req_o   (req_nx[g]),
            .wdraw_o (wdr_nx[g])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.prev = irq_i;
        state_d.pend = pend_nx;
        state_d.req  = req_nx;
        state_d.wdr  = wdr_nx;
        for (int k = 0; k < EXT_COUNT; k++) begin
            if (mode_wr_w[k]) begin
                state_d.mode[EXT_BASE+k] = mode_val_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.prev <= '0;
            state_q.pend <= '0;
            state_q.req  <= '0;
            state_q.wdr  <= '0;
            state_q.mode <= MODE_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend_o      = state_q.pend;
    assign req_stb_o   = state_q.req;
    assign wdraw_stb_o = state_q.wdr;

endmodule

// File: rtl/trig_detect_chk.sv
module trig_detect_chk #(
    parameter int NUM_SRC  = 96,
    parameter int EXT_BASE = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SRC-1:0]       pend,
    input logic [NUM_SRC-1:0]       req,
    input logic [NUM_SRC-1:0]       wdr,
    input logic [NUM_SRC-1:0][1:0]  mode
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (pend == '0 && req == '0 && wdr == '0));

    // R2
    req_implies_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req & ~pend) == '0);

    // R3
    wdraw_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdr & pend) == '0);

    // R3
    wdraw_needs_prior_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wdr) |-> ((wdr & ~$past(pend)) == '0));

    // R8
    fixed_modes_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode[EXT_BASE-1:0]));

endmodule

bind trig_detect trig_detect_chk #(
    .NUM_SRC  (NUM_SRC),
    .EXT_BASE (EXT_BASE)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend_o),
    .req   (req_stb_o),
    .wdr   (wdraw_stb_o),
    .mode  (state_q.mode)
);

// File: tb/trig_detect_tb_top.sv
module trig_detect_tb_top;

    localparam int N    = 96;
    localparam int IDW  = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   irq = '0;
    logic           ack_v = 1'b0;
    logic [IDW-1:0] ack_id = '0;
    logic           wr = 1'b0;
    logic [IDW:0]   addr = '0;
    logic [7:0]     wdata = '0;
    logic [7:0]     rdata;
    logic [N-1:0]   pend;
    logic [N-1:0]   req;
    logic [N-1:0]   wdr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trig_detect dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq),
        .ack_valid_i (ack_v),
        .ack_id_i    (ack_id),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pend_o      (pend),
        .req_stb_o   (req),
        .wdraw_stb_o (wdr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic reg_write(input logic win, input int idx, input logic [7:0] d);
        wr    = 1'b1;
        addr  = {win, IDW'(idx)};
        wdata = d;
        tick();
        wr    = 1'b0;
        wdata = '0;
    endtask

    task automatic reg_read(input logic win, input int idx, output logic [7:0] d);
        addr = {win, IDW'(idx)};
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 pend", 32'(pend != '0), 0);
        chk("R1 req", 32'(req != '0), 0);
        chk("R1 wdraw", 32'(wdr != '0), 0);
        reg_read(1'b1, 6, v);
        chk("R1 src70 level", 32'(v), 32'h00);
        reg_read(1'b1, 0, v);
        chk("R1 src64 rising", 32'(v), 32'h08);
    endtask

    task automatic t_level();
        logic [7:0] v;
        irq[3] = 1'b1;
        tick();
        chk("R2 level set", 32'(pend[3]), 1);
        chk("R2 level req", 32'(req[3]), 1);
        tick();
        chk("R2 level no repeat req", 32'(req[3]), 0);
        chk("R2 level held", 32'(pend[3]), 1);
        reg_read(1'b0, 3, v);
        chk("R10 pending read", 32'(v), 32'h01);
        reg_write(1'b0, 3, 8'h00);
        chk("R9 level write ignored", 32'(pend[3]), 1);
        ack_v = 1'b1; ack_id = 7'd3;
        tick();
        ack_v = 1'b0;
        chk("R11 level ack ignored", 32'(pend[3]), 1);
        irq[3] = 1'b0;
        tick();
        chk("R3 level cleared", 32'(pend[3]), 0);
        chk("R3 withdraw", 32'(wdr[3]), 1);
        tick();
        chk("R3 withdraw one cycle", 32'(wdr[3]), 0);
    endtask

    task automatic t_rise();
        logic [7:0] v;
        irq[5] = 1'b1;
        tick();
        chk("R5 rise set", 32'(pend[5]), 1);
        chk("R5 rise req", 32'(req[5]), 1);
        tick();
        chk("R13 req one cycle", 32'(req[5]), 0);
        irq[5] = 1'b0;
        tick();
        chk("R5 fall no req", 32'(req[5]), 0);
        chk("R5 flag kept", 32'(pend[5]), 1);
        reg_write(1'b0, 5, 8'h02);
        chk("R9 nonzero ignored", 32'(pend[5]), 1);
        reg_write(1'b0, 5, 8'h00);
        chk("R9 zero clears", 32'(pend[5]), 0);
        reg_read(1'b0, 5, v);
        chk("R10 cleared read", 32'(v), 32'h00);
    endtask

    task automatic t_fall();
        logic [7:0] v;
        reg_write(1'b1, 1, 8'hF7);
        reg_read(1'b1, 1, v);
        chk("R8 mode readback", 32'(v), 32'h04);
        irq[65] = 1'b1;
        tick();
        chk("R4 rise ignored", 32'(pend[65]), 0);
        irq[65] = 1'b0;
        tick();
        chk("R4 fall set", 32'(pend[65]), 1);
        chk("R4 fall req", 32'(req[65]), 1);
        ack_v = 1'b1; ack_id = 7'd65;
        tick();
        ack_v = 1'b0;
        chk("R11 ack clears edge", 32'(pend[65]), 0);
    endtask

    task automatic t_any();
        reg_write(1'b1, 2, 8'h0C);
        irq[66] = 1'b1;
        tick();
        chk("R6 up req", 32'(req[66]), 1);
        reg_write(1'b0, 66, 8'h00);
        chk("R6 cleared", 32'(pend[66]), 0);
        irq[66] = 1'b0;
        tick();
        chk("R6 down set", 32'(pend[66]), 1);
        chk("R6 down req", 32'(req[66]), 1);
    endtask

    task automatic t_prev();
        reg_write(1'b1, 3, 8'h04);
        irq[67] = 1'b1;
        tick();
        chk("R7 rise in fall mode", 32'(pend[67]), 0);
        reg_write(1'b1, 3, 8'h08);
        tick();
        chk("R7 no stale edge", 32'(pend[67]), 0);
        chk("R7 no stale req", 32'(req[67]), 0);
    endtask

    task automatic t_race();
        irq[5] = 1'b1;
        wr = 1'b1; addr = {1'b0, 7'd5}; wdata = 8'h00;
        tick();
        wr = 1'b0;
        chk("R12 edge beats write clear", 32'(pend[5]), 1);
        chk("R12 req on race", 32'(req[5]), 1);
        irq[66] = 1'b1;
        ack_v = 1'b1; ack_id = 7'd66;
        tick();
        ack_v = 1'b0;
        chk("R12 edge beats ack", 32'(pend[66]), 1);
        chk("R12 ack race req", 32'(req[66]), 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_level();
        t_rise();
        t_fall();
        t_any();
        t_prev();
        t_race();
        repeat (2) tick();
        finish_run();
    end

endmodule